// File: doc/BRIEF.md
# Scanned Key Matrix Encoder with Keystroke Queue

This block walks the columns of a key matrix of up to eight by eight, watches eight pulled-up return lines in step with that walk, and turns each debounced key closure into one byte holding the column, the row and the state of the control and shift inputs at acceptance time. The bytes wait in an eight-entry queue until a host pops them. A status byte shows the fill level and the sticky error flags, and an interrupt line tells the host that keystrokes are waiting.

Three acceptance policies are selected by a 3-bit mode input. With rollover, every debounced key is queued in the order it became stable. With lockout, a key is refused while another key is also closed. With strobed capture, the scan keeps running, the matrix logic sits idle, and each rising edge of the control/strobe input pushes the raw return lines into the queue. A separate mode bit chooses the column output format: a binary count, or a one-cold pattern over four columns.

Top module: `kbd_scan_encoder`

## Requirements
- R1: With mode bit 0 low, `sl_o` is the column number 0 to 7 as an active-high binary value with bit 3 at 0. It advances by one every TICK_DIV clocks and wraps from 7 to 0.
- R2: With mode bit 0 high, exactly one bit of `sl_o` is low. The pattern steps 1110, 1101, 1011, 0111 and repeats, and only four columns are scanned.
- R3: An accepted key is queued as bit 7 = control input, bit 6 = shift input, bits 5..3 = column number and bits 2..0 = row index of the closed return line. Control and shift are taken at the moment of acceptance.
- R4: A key is queued only after it has read closed (return line low) at two scans of its column in a row. It is queued once per press and must read open before it can be queued again.
- R5: With mode bits 2..1 = 01 (rollover), every key that stays closed long enough is queued, and keys pressed at different times come out in the order they were pressed.
- R6: With mode bits 2..1 = 00 (lockout), a key is not queued while more than one key is closed. Such a refusal sets status bit 6. Once the other keys are released, the remaining key is queued.
- R7: With mode bit 2 high, each rising edge of `ctrl_strb_i` pushes the raw `ret_n_i` byte into the queue.
- R8: The queue holds eight bytes and returns them first in, first out. A one-cycle `rd_i` pulse places the oldest byte on `rd_data_o` at the next clock edge. Without a read, `rd_data_o` holds its value.
- R9: A push into a full queue is dropped and sets status bit 5. A push in the same cycle as a read of a full queue is accepted.
- R10: A read of an empty queue sets status bit 4 and leaves `rd_data_o` unchanged.
- R11: Status bit 7 reads 0, bit 3 is set when eight bytes are held, and bits 2..0 give the number of bytes held modulo eight.
- R12: `irq_o` rises when a byte is pushed and is low whenever the queue is empty. An `eoi_i` pulse lowers it until the next push.
- R13: A `clr_i` pulse empties the queue, clears status bits 6..0 and lowers `irq_o`. It takes priority over a push or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Bit 0 column format (1 = one-cold), bit 1 rollover, bit 2 strobed capture |
| ret_n_i | input | 8 | Return lines, low = closed key on the driven column |
| shift_i | input | 1 | Shift key level |
| ctrl_strb_i | input | 1 | Control key level, or capture strobe in strobed mode |
| rd_i | input | 1 | Pop one byte from the queue |
| clr_i | input | 1 | Empty the queue and clear status |
| eoi_i | input | 1 | Acknowledge the interrupt |
| sl_o | output | 4 | Column drive |
| rd_data_o | output | 8 | Last byte popped |
| status_o | output | 8 | Error flags, full flag and fill count |
| irq_o | output | 1 | Keystrokes waiting |

## Verification
A push and a pop can land on the same clock edge, and the case that matters is the one with the queue full. The bench fills the queue through eight strobes, then raises the strobe and the read request in the same cycle. It judges the result by the popped byte being the oldest entry, by the status showing full with no overrun, and by the pushed byte coming out last when the queue is drained. A clear that meets a strobe in one cycle is provoked in the same way and must leave the status at zero.

// File: rtl/kbd_pkg.sv
// Shared constants and helpers for the key matrix encoder.
// Assumes a matrix of at most eight columns by eight rows.
package kbd_pkg;
    localparam int COLS   = 8;
    localparam int ROWS   = 8;
    localparam int SCAN_W = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int SL_W   = 4;
    localparam int CODE_W = 2 + SCAN_W + ROW_W;

    // Count the ones in a row-wide vector.
    function automatic logic [ROW_W:0] ones_in_row(input logic [ROWS-1:0] v);
        logic [ROW_W:0] n;
        n = '0;
        for (int i = 0; i < ROWS; i++) begin
            n = n + {{ROW_W{1'b0}}, v[i]};
        end
        return n;
    endfunction
endpackage

// File: rtl/kbd_scan_timer.sv
// Column walker: divides the clock into scan steps and drives the column lines.
// Assumes TICK_DIV >= 2. Binary drive counts 0..COLS-1; one-cold drive rotates
// over four columns, wrapping whenever the low two bits of the count reach 3.
module kbd_scan_timer
    import kbd_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              decoded,
    output logic              tick,
    output logic              frame_end,
    output logic [SCAN_W-1:0] scan_cnt,
    output logic [SL_W-1:0]   sl
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0]     pre_q;
    logic [SCAN_W-1:0] col_q;
    logic              wrap;
    logic [SL_W-1:0]   sl_dec;
    logic [SL_W-1:0]   sl_enc;

    assign tick      = (pre_q == PW'(TICK_DIV - 1));
    assign wrap      = decoded ? (col_q[1:0] == 2'b11) : (col_q == SCAN_W'(COLS - 1));
    assign frame_end = tick & wrap;
    assign scan_cnt  = col_q;

    // Prescaler: one scan step every TICK_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Column counter: advance at each step, wrap at the last column of the format.
    always_ff @(posedge clk) begin
        if (!rst_n)        col_q <= '0;
        else if (tick)     col_q <= wrap ? '0 : col_q + 1'b1;
    end

    // One-cold drive: the low two count bits select the single low line.
    for (genvar c = 0; c < SL_W; c++) begin : g_dec
        assign sl_dec[c] = (col_q[1:0] != 2'(c));
    end

    assign sl_enc = {{(SL_W - SCAN_W){1'b0}}, col_q};
    assign sl     = decoded ? sl_dec : sl_enc;
endmodule

// File: rtl/kbd_key_tracker.sv
// Per-key debounce and acceptance. Each key keeps a saturating count of
// consecutive closed samples and a "queued" flag that clears on release.
// Lockout accepts only when the previous full frame and the current column
// both saw exactly one closed key. At most one key is accepted per scan step
// (the lowest row); others wait for their next scan. Held idle while disabled.
module kbd_key_tracker
    import kbd_pkg::*;
#(
    parameter int DEB_SCANS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              rollover,
    input  logic              tick,
    input  logic              frame_end,
    input  logic [SCAN_W-1:0] scan_cnt,
    input  logic [ROWS-1:0]   ret_n,
    input  logic              ctrl,
    input  logic              shift,
    output logic              push_v,
    output logic [CODE_W-1:0] push_code,
    output logic              lock_err
);
    localparam int CW   = $clog2(DEB_SCANS + 1);
    localparam int KEYS = COLS * ROWS;
    localparam int IW   = $clog2(KEYS);
    localparam int TW   = $clog2(KEYS + 1);

    logic [CW-1:0]   cnt_q [KEYS];
    logic [KEYS-1:0] queued_q;
    logic [TW-1:0]   acc_q;
    logic [TW-1:0]   prev_q;

    logic [IW-1:0]   idx     [ROWS];
    logic [CW-1:0]   nxt_cnt [ROWS];
    logic [ROWS-1:0] closed;
    logic [ROWS-1:0] ready;
    logic [ROWS-1:0] take;
    logic [ROW_W:0]  pc;
    logic            lock_ok;
    logic            found;
    logic [ROW_W-1:0] sel;

    // Per-row view of the key under the current column.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign idx[r]     = {scan_cnt, ROW_W'(r)};
        assign closed[r]  = ~ret_n[r];
        assign nxt_cnt[r] = !closed[r] ? '0 :
                            (cnt_q[idx[r]] == CW'(DEB_SCANS)) ? cnt_q[idx[r]] :
                            cnt_q[idx[r]] + 1'b1;
        assign ready[r]   = closed[r] && (nxt_cnt[r] == CW'(DEB_SCANS)) && !queued_q[idx[r]];
    end

    assign pc      = ones_in_row(closed);
    assign lock_ok = (prev_q == TW'(1)) && (pc == (ROW_W + 1)'(1));
    assign take    = (rollover || lock_ok) ? ready : '0;

    // Pick the lowest eligible row for this step.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (take[r]) begin
                found = 1'b1;
                sel   = ROW_W'(r);
            end
        end
    end

    // Key state, frame occupancy and the registered accept output.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            for (int k = 0; k < KEYS; k++) cnt_q[k] <= '0;
            queued_q  <= '0;
            acc_q     <= '0;
            prev_q    <= '0;
            push_v    <= 1'b0;
            push_code <= '0;
            lock_err  <= 1'b0;
        end else begin
            push_v   <= 1'b0;
            lock_err <= 1'b0;
            if (tick) begin
                for (int r = 0; r < ROWS; r++) begin
                    cnt_q[idx[r]] <= nxt_cnt[r];
                    if (!closed[r]) queued_q[idx[r]] <= 1'b0;
                end
                if (found) begin
                    queued_q[{scan_cnt, sel}] <= 1'b1;
                    push_v    <= 1'b1;
                    push_code <= {ctrl, shift, scan_cnt, sel};
                end
                lock_err <= !rollover && (ready != '0) && !lock_ok;
                if (frame_end) begin
                    prev_q <= acc_q + TW'(pc);
                    acc_q  <= '0;
                end else begin
                    acc_q  <= acc_q + TW'(pc);
                end
            end
        end
    end
endmodule

// File: rtl/kbd_key_fifo.sv
// Keystroke queue with sticky overrun, underrun and lockout-error flags.
// Assumes DEPTH is a power of two. A read frees a slot before a push in the
// same cycle is judged; clear overrides both.
module kbd_key_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    input  logic                       clr,
    input  logic                       err_set,
    output logic [W-1:0]               rd_data,
    output logic [$clog2(DEPTH)-1:0]   cnt_low,
    output logic                       full,
    output logic                       empty,
    output logic                       push_ok,
    output logic                       ovr,
    output logic                       unr,
    output logic                       err
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic [AW:0]   cnt_q;
    logic          do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == (AW + 1)'(DEPTH));
    assign do_pop  = pop && !empty;
    assign push_ok = push && !clr && (!full || do_pop);
    assign cnt_low = cnt_q[AW-1:0];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem_q[wptr_q] <= push_data;
    end

    // Pointers, fill count, read data and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            cnt_q   <= '0;
            rd_data <= '0;
            ovr     <= 1'b0;
            unr     <= 1'b0;
            err     <= 1'b0;
        end else if (clr) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            cnt_q   <= '0;
            ovr     <= 1'b0;
            unr     <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (do_pop) begin
                rd_data <= mem_q[rptr_q];
                rptr_q  <= rptr_q + 1'b1;
            end
            case ({push_ok, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && !push_ok) ovr <= 1'b1;
            if (pop && empty)     unr <= 1'b1;
            if (err_set)          err <= 1'b1;
        end
    end
endmodule

// File: rtl/kbd_scan_encoder.sv
// Top level: column scan, key acceptance, strobed capture, keystroke queue,
// status byte and interrupt. Inputs are assumed synchronous to clk.
// mode_i: bit 0 one-cold columns, bit 1 rollover, bit 2 strobed capture.
module kbd_scan_encoder
    import kbd_pkg::*;
#(
    parameter int TICK_DIV  = 4,
    parameter int DEB_SCANS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [ROWS-1:0]   ret_n_i,
    input  logic              shift_i,
    input  logic              ctrl_strb_i,
    input  logic              rd_i,
    input  logic              clr_i,
    input  logic              eoi_i,
    output logic [SL_W-1:0]   sl_o,
    output logic [CODE_W-1:0] rd_data_o,
    output logic [7:0]        status_o,
    output logic              irq_o
);
    localparam int QDEPTH = 8;
    localparam int QAW    = $clog2(QDEPTH);

    logic              tick;
    logic              frame_end;
    logic [SCAN_W-1:0] scan_cnt;
    logic              trk_push;
    logic [CODE_W-1:0] trk_code;
    logic              lock_err;
    logic              strobed;
    logic              strb_q;
    logic              strb_rise;
    logic              q_push;
    logic [CODE_W-1:0] q_data;
    logic [QAW-1:0]    q_cnt;
    logic              q_full;
    logic              q_empty;
    logic              q_push_ok;
    logic              q_ovr;
    logic              q_unr;
    logic              q_err;
    logic              irq_q;

    assign strobed = mode_i[2];

    kbd_scan_timer #(.TICK_DIV(TICK_DIV)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .decoded   (mode_i[0]),
        .tick      (tick),
        .frame_end (frame_end),
        .scan_cnt  (scan_cnt),
        .sl        (sl_o)
    );

    kbd_key_tracker #(.DEB_SCANS(DEB_SCANS)) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!strobed),
        .rollover  (mode_i[1]),
        .tick      (tick),
        .frame_end (frame_end),
        .scan_cnt  (scan_cnt),
        .ret_n     (ret_n_i),
        .ctrl      (ctrl_strb_i),
        .shift     (shift_i),
        .push_v    (trk_push),
        .push_code (trk_code),
        .lock_err  (lock_err)
    );

    // Strobe history for rising-edge capture.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= ctrl_strb_i;
    end

    assign strb_rise = strobed && ctrl_strb_i && !strb_q;
    assign q_push    = strobed ? strb_rise : trk_push;
    assign q_data    = strobed ? ret_n_i   : trk_code;

    kbd_key_fifo #(.DEPTH(QDEPTH), .W(CODE_W)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (q_data),
        .pop       (rd_i),
        .clr       (clr_i),
        .err_set   (lock_err),
        .rd_data   (rd_data_o),
        .cnt_low   (q_cnt),
        .full      (q_full),
        .empty     (q_empty),
        .push_ok   (q_push_ok),
        .ovr       (q_ovr),
        .unr       (q_unr),
        .err       (q_err)
    );

    // Interrupt latch: set by a push, dropped by acknowledge or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) irq_q <= 1'b0;
        else if (q_push_ok)  irq_q <= 1'b1;
        else if (eoi_i)      irq_q <= 1'b0;
    end

    assign irq_o    = irq_q && !q_empty;
    assign status_o = {1'b0, q_err, q_ovr, q_unr, q_full, q_cnt};
endmodule

// File: rtl/kbd_scan_encoder_chk.sv
// Port-level properties of the key matrix encoder, attached by bind.
module kbd_scan_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic [3:0] sl_o,
    input logic       rd_i,
    input logic       clr_i,
    input logic [7:0] rd_data_o,
    input logic [7:0] status_o,
    input logic       irq_o
);
    AST_BINARY_TOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[0] |-> !sl_o[3]); // R1

    AST_ONE_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[0] |-> ($countones(sl_o) == 3)); // R2

    AST_COLD_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[0] && $past(mode_i[0]) && (sl_o != $past(sl_o)))
        |-> (sl_o == ((($past(sl_o) << 1) | ($past(sl_o) >> 3)) & 4'hF))); // R2

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o)); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[5] && !clr_i) |=> status_o[5]); // R9

    AST_EMPTY_READ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !clr_i && (status_o[3:0] == 4'h0)) |=> status_o[4]); // R10

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[3] || (status_o[2:0] != 3'd0))); // R12

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ((status_o[6:0] == 7'd0) && !irq_o)); // R13
endmodule

bind kbd_scan_encoder kbd_scan_encoder_chk i_kbd_chk (.*);

// File: tb/test_kbd_scan_encoder.sv
// Directed bench: a behavioural key matrix answers the column drive.
module test_kbd_scan_encoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode;
    logic [7:0] ret_n;
    logic       shift;
    logic       strb;
    logic       rd;
    logic       clr;
    logic       eoi;
    logic [3:0] sl_o;
    logic [7:0] rd_data_o;
    logic [7:0] status_o;
    logic       irq_o;

    logic [63:0] keys;
    logic        use_raw;
    logic [7:0]  raw;
    logic [2:0]  col_m;
    logic [7:0]  ret_model;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    // Column decode from the drive lines, as the requirements define them.
    always_comb begin
        col_m = sl_o[2:0];
        if (mode[0]) begin
            col_m = 3'd0;
            for (int c = 0; c < 4; c++) if (!sl_o[c]) col_m = 3'(c);
        end
        for (int r = 0; r < 8; r++) ret_model[r] = ~keys[int'(col_m) * 8 + r];
    end

    assign ret_n = use_raw ? raw : ret_model;

    kbd_scan_encoder i_kbd_scan_encoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .ret_n_i     (ret_n),
        .shift_i     (shift),
        .ctrl_strb_i (strb),
        .rd_i        (rd),
        .clr_i       (clr),
        .eoi_i       (eoi),
        .sl_o        (sl_o),
        .rd_data_o   (rd_data_o),
        .status_o    (status_o),
        .irq_o       (irq_o)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_read(output logic [7:0] d);
        rd = 1'b1;
        cyc(1);
        rd = 1'b0;
        d = rd_data_o;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        cyc(1);
        clr = 1'b0;
    endtask

    task automatic strobe(input logic [7:0] v);
        raw  = v;
        strb = 1'b1;
        cyc(1);
        strb = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        chk("R11 reset status", status_o, 8'h00);
        chk("R12 reset irq", {7'd0, irq_o}, 8'h00);
        chk("R8 reset data", rd_data_o, 8'h00);
        chk("R1 reset column", {4'd0, sl_o}, 8'h00);
    endtask

    task automatic t_scan_binary();
        mode = 3'b000;
        while (sl_o == 4'd0) cyc(1);
        while (sl_o != 4'd0) cyc(1);
        for (int k = 0; k < 16; k++) begin
            chk("R1 binary column", {4'd0, sl_o}, 8'(k % 8));
            cyc(4);
        end
    endtask

    task automatic t_scan_cold();
        logic [3:0] exp;
        mode = 3'b001;
        while (sl_o == 4'b1110) cyc(1);
        while (sl_o != 4'b1110) cyc(1);
        exp = 4'b1110;
        for (int k = 0; k < 8; k++) begin
            chk("R2 one-cold column", {4'd0, sl_o}, {4'd0, exp});
            exp = {exp[2:0], exp[3]};
            cyc(4);
        end
    endtask

    task automatic t_debounce();
        logic [7:0] d;
        mode = 3'b010; shift = 1'b0; strb = 1'b0;
        keys = '0; cyc(80); pulse_clr();
        keys[1*8+0] = 1'b1;
        cyc(30);
        chk("R4 one scan not enough", status_o, 8'h00);
        cyc(50);
        chk("R4 accepted after two scans", status_o, 8'h01);
        cyc(200);
        chk("R4 held key queued once", status_o, 8'h01);
        keys = '0; cyc(100);
        keys[1*8+0] = 1'b1; cyc(100);
        chk("R4 re-press after release", status_o, 8'h02);
        host_read(d);
        chk("R3 code col1 row0", d, 8'h08);
        host_read(d);
        chk("R4 second code", d, 8'h08);
        keys = '0; cyc(80);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        mode = 3'b010; pulse_clr();
        strb = 1'b1; shift = 1'b0;
        keys[5*8+2] = 1'b1; cyc(100);
        chk("R12 irq after key", {7'd0, irq_o}, 8'h01);
        host_read(d);
        chk("R3 ctrl col5 row2", d, 8'hAA);
        keys = '0; strb = 1'b0; shift = 1'b1; cyc(80);
        keys[7*8+6] = 1'b1; cyc(100);
        host_read(d);
        chk("R3 shift col7 row6", d, 8'h7E);
        chk("R12 irq low when empty", {7'd0, irq_o}, 8'h00);
        keys = '0; shift = 1'b0; cyc(80);
    endtask

    task automatic t_rollover();
        logic [7:0] d;
        mode = 3'b010; pulse_clr();
        keys[2*8+7] = 1'b1; cyc(100);
        keys[6*8+0] = 1'b1; cyc(100);
        chk("R5 both keys queued", status_o, 8'h02);
        host_read(d);
        chk("R5 first pressed first", d, 8'h17);
        host_read(d);
        chk("R5 second pressed second", d, 8'h30);
        keys = '0; cyc(80);
    endtask

    task automatic t_lockout();
        logic [7:0] d;
        mode = 3'b000; cyc(80); pulse_clr();
        keys[3*8+1] = 1'b1; keys[3*8+4] = 1'b1;
        cyc(150);
        chk("R6 two keys refused, error set", status_o, 8'h40);
        keys[3*8+4] = 1'b0;
        cyc(150);
        chk("R6 survivor queued", status_o, 8'h41);
        host_read(d);
        chk("R6 survivor code", d, 8'h19);
        keys = '0; cyc(80); pulse_clr();
    endtask

    task automatic t_strobe_overrun();
        logic [7:0] d;
        mode = 3'b110; use_raw = 1'b1; cyc(4); pulse_clr();
        for (int k = 0; k < 9; k++) strobe(8'hA0 + 8'(k));
        chk("R9 full with overrun", status_o, 8'h28);
        for (int k = 0; k < 8; k++) begin
            host_read(d);
            chk("R7 R8 raw capture in order", d, 8'hA0 + 8'(k));
        end
        chk("R11 empty keeps overrun", status_o, 8'h20);
        host_read(d);
        chk("R10 empty read keeps data", d, 8'hA7);
        chk("R10 underrun flag", status_o, 8'h30);
        chk("R12 irq low when empty", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_push_pop_full();
        logic [7:0] d;
        pulse_clr();
        for (int k = 0; k < 8; k++) strobe(8'hB0 + 8'(k));
        chk("R11 full count wraps", status_o, 8'h08);
        raw = 8'hC0; strb = 1'b1; rd = 1'b1;
        cyc(1);
        strb = 1'b0; rd = 1'b0;
        chk("R9 read beside push gives oldest", rd_data_o, 8'hB0);
        chk("R9 no overrun on push with read", status_o, 8'h08);
        cyc(1);
        for (int k = 1; k < 9; k++) begin
            host_read(d);
            chk("R9 order after shared cycle", d, (k < 8) ? 8'hB0 + 8'(k) : 8'hC0);
        end
    endtask

    task automatic t_eoi();
        logic [7:0] d;
        pulse_clr();
        strobe(8'h11);
        chk("R12 irq on push", {7'd0, irq_o}, 8'h01);
        eoi = 1'b1; cyc(1); eoi = 1'b0;
        chk("R12 eoi lowers irq", {7'd0, irq_o}, 8'h00);
        chk("R12 eoi keeps data", status_o, 8'h01);
        strobe(8'h22);
        chk("R12 irq on next push", {7'd0, irq_o}, 8'h01);
        host_read(d);
        host_read(d);
        chk("R12 irq low after drain", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_clear();
        strobe(8'h33);
        host_read(raw); host_read(raw);
        strobe(8'h34);
        pulse_clr();
        chk("R13 clear empties and resets flags", status_o, 8'h00);
        chk("R13 clear lowers irq", {7'd0, irq_o}, 8'h00);
        raw = 8'h44; strb = 1'b1; clr = 1'b1;
        cyc(1);
        strb = 1'b0; clr = 1'b0;
        chk("R13 clear beats push", status_o, 8'h00);
        cyc(1);
    endtask

    initial begin
        rst_n = 1'b0; mode = 3'b000; shift = 1'b0; strb = 1'b0;
        rd = 1'b0; clr = 1'b0; eoi = 1'b0;
        keys = '0; use_raw = 1'b0; raw = 8'hFF;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_scan_binary();
        t_scan_cold();
        t_debounce();
        t_layout();
        t_rollover();
        t_lockout();
        t_strobe_overrun();
        t_push_pop_full();
        t_eoi();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule